// File: doc/BRIEF.md
# Dual-Rail Power-Good Qualifier

This block watches two switching regulator rails and produces a single power-good release. Each rail supplies an enable bit and an in-range flag. The in-range flag comes from an analog window comparator and is asynchronous to the block clock. Rails that are disabled take no part in the decision. Every enabled rail must report in range before the output may be released. When no rail is enabled, the output stays low.

Release does not follow the good condition at once. It waits a programmable number of milliseconds, counted with a tick from an internal prescaler on the system clock. Losing the good condition pulls the output low in the same cycle and sends the count back to zero. The release signal is active high and drives an open-drain pad: a low level pulls the pad down (not good), and a high level lets it float up (good).

Top module: `dual_rail_pgood`

## Requirements
- R1: With both rails enabled (enable code 2'b11), the output is released only while both synchronized in-range flags are high; a low flag on either rail pulls it low.
- R2: With exactly one rail enabled (enable bit 0 alone, code 2'b01), the output depends only on that rail's flag (bit 0 of the flag input); the flag of the disabled rail has no effect.
- R3: With no rail enabled (code 2'b00), the output is held low whatever the flags are.
- R4: Once the good condition is seen by the qualifier, the output rises exactly D×TICK_DIV clock edges later, where D is the delay in milliseconds.
- R5: When the synchronized good condition turns false, the output goes low in that same cycle, with no delay and no count.
- R6: A loss of the good condition during the delay count restarts the count from zero, and the output stays low until a full new delay has elapsed.
- R7: The 8-bit delay input gives whole milliseconds; a value of 0 acts as 1 ms and any value above 200 acts as 200 ms.
- R8: The delay value is captured when qualification starts; a change to the delay input while counting or released takes effect only at the next qualification.
- R9: Each in-range flag passes through a two-flop synchronizer, so a flag change reaches the output after exactly two clock edges.
- R10: Synchronous active-low reset forces the output low, clears the synchronizer and the delay counter, and a full delay is needed after reset before release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; also feeds the millisecond prescaler |
| rst_ni | input | 1 | Synchronous reset, active low |
| rail_en_i | input | N_RAILS | Per-rail enable bits, synchronous to clk_i |
| rail_ok_async_i | input | N_RAILS | Per-rail in-range flags from the comparators, asynchronous |
| dly_ms_i | input | DLY_W | Qualification delay in milliseconds, from the register interface |
| pg_release_o | output | 1 | 1 = release the open-drain pad (good), 0 = pull it low (not good) |

## Verification
The rails are tried with both enabled, with one enabled while the other rail's flag toggles freely, and with none enabled while both flags are high. Together these show that the good condition is a check of enabled rails only, and not a plain AND or OR of the flags. Delay runs at the clamped extremes (0 and 255) and at a mid value are timed to the exact edge. A glitch in the middle of a count separates a counter that restarts from one that pauses or carries on. Delay writes made while the output is released, and a reset while it is released, show whether the delay value and the counter are captured and cleared at the right moments.

// File: rtl/pgq_pkg.sv
// Package: shared types for the dual-rail power-good qualifier.
// Assumes: nothing beyond IEEE 1800-2017.
package pgq_pkg;

    // Qualifier state: waiting for good, counting the delay, released.
    typedef enum logic [1:0] {
        QS_IDLE  = 2'd0,
        QS_COUNT = 2'd1,
        QS_REL   = 2'd2
    } qstate_t;

endpackage

// File: rtl/pgq_sync.sv
// Module: pgq_sync
// Two-flop synchronizer for a vector of independent level flags.
// Assumes: each bit is a slow level from its own source; no bus
// coherence between bits is needed. Reset clears both stages.
module pgq_sync #(
    parameter int unsigned W = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Capture the asynchronous flags and let metastability settle one stage.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;

endmodule

// File: rtl/pgq_rail_combine.sv
// Module: pgq_rail_combine
// Forms the good condition from per-rail enables and synchronized flags:
// every enabled rail must be in range and at least one rail enabled.
// Assumes: flags are already synchronous to the block clock.
module pgq_rail_combine #(
    parameter int unsigned N_RAILS = 2
) (
    input  logic [N_RAILS-1:0] en_i,
    input  logic [N_RAILS-1:0] ok_i,
    output logic               good_o
);

    logic [N_RAILS-1:0] rail_pass;

    // A disabled rail passes; an enabled rail passes only when in range.
    for (genvar g = 0; g < N_RAILS; g++) begin : g_rail
        assign rail_pass[g] = ~en_i[g] | ok_i[g];
    end

    // At least one enabled rail and no enabled rail out of range.
    assign good_o = (|en_i) & (&rail_pass);

endmodule

// File: rtl/pgq_prescale.sv
// Module: pgq_prescale
// Millisecond prescaler: divides the system clock by TICK_DIV while run_i
// is high and emits a one-cycle tick at the end of each period.
// Assumes: TICK_DIV >= 2. Dropping run_i restarts the period from zero,
// so each count begins on a whole-millisecond boundary.
module pgq_prescale #(
    parameter int unsigned TICK_DIV = 1000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic tick_o
);

    localparam int unsigned CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt_q;

    // Count clock cycles inside one millisecond period; clear when idle.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/pgq_qual_fsm.sv
// Module: pgq_qual_fsm
// Qualification state machine. It latches the clamped delay when the good
// condition first appears, counts millisecond ticks, and enters the
// released state after the latched number of ticks.
// Assumes: good_i is synchronous; tick_i is high only while counting.
module pgq_qual_fsm
    import pgq_pkg::*;
#(
    parameter int unsigned DLY_W   = 8,
    parameter int unsigned DLY_MIN = 1,
    parameter int unsigned DLY_MAX = 200
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             good_i,
    input  logic             tick_i,
    input  logic [DLY_W-1:0] dly_ms_i,
    output qstate_t          state_o,
    output logic [DLY_W-1:0] ms_cnt_o,
    output logic [DLY_W-1:0] target_o,
    output logic             counting_o,
    output logic             rel_o
);

    localparam logic [DLY_W-1:0] MIN_V = DLY_W'(DLY_MIN);
    localparam logic [DLY_W-1:0] MAX_V = DLY_W'(DLY_MAX);

    qstate_t          st_q;
    logic [DLY_W-1:0] ms_q;
    logic [DLY_W-1:0] tgt_q;

    // Limit the programmed delay to the supported millisecond range.
    function automatic logic [DLY_W-1:0] clamp_ms(input logic [DLY_W-1:0] d);
        if (d < MIN_V) begin
            return MIN_V;
        end else if (d > MAX_V) begin
            return MAX_V;
        end
        return d;
    endfunction

    // Advance the qualifier state, the tick counter and the latched delay.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q  <= QS_IDLE;
            ms_q  <= '0;
            tgt_q <= MIN_V;
        end else begin
            unique case (st_q)
                QS_IDLE: begin
                    tgt_q <= clamp_ms(dly_ms_i);
                    ms_q  <= '0;
                    if (good_i) begin
                        st_q <= QS_COUNT;
                    end
                end
                QS_COUNT: begin
                    if (!good_i) begin
                        st_q <= QS_IDLE;
                        ms_q <= '0;
                    end else if (tick_i) begin
                        if (ms_q == tgt_q - 1'b1) begin
                            st_q <= QS_REL;
                            ms_q <= '0;
                        end else begin
                            ms_q <= ms_q + 1'b1;
                        end
                    end
                end
                QS_REL: begin
                    if (!good_i) begin
                        st_q <= QS_IDLE;
                    end
                end
                default: begin
                    st_q <= QS_IDLE;
                    ms_q <= '0;
                end
            endcase
        end
    end

    assign state_o    = st_q;
    assign ms_cnt_o   = ms_q;
    assign target_o   = tgt_q;
    assign counting_o = (st_q == QS_COUNT);
    assign rel_o      = (st_q == QS_REL);

endmodule

// File: rtl/dual_rail_pgood.sv
// Module: dual_rail_pgood (top)
// Dual-rail power-good qualifier. Synchronizes the comparator flags,
// combines them with the rail enables, and releases the open-drain
// output after a programmable millisecond delay. A fault gates the
// output low at once.
// Assumes: rail_en_i and dly_ms_i are synchronous to clk_i; TICK_DIV is
// the number of clk_i cycles in one millisecond.
module dual_rail_pgood
    import pgq_pkg::*;
#(
    parameter int unsigned N_RAILS  = 2,
    parameter int unsigned TICK_DIV = 1000,
    parameter int unsigned DLY_W    = 8,
    parameter int unsigned DLY_MIN  = 1,
    parameter int unsigned DLY_MAX  = 200
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [N_RAILS-1:0] rail_en_i,
    input  logic [N_RAILS-1:0] rail_ok_async_i,
    input  logic [DLY_W-1:0]   dly_ms_i,
    output logic               pg_release_o
);

    logic [N_RAILS-1:0] rail_ok_s;
    logic               good_w;
    logic               tick_w;
    logic               counting_w;
    logic               rel_w;
    qstate_t            st_w;
    logic [DLY_W-1:0]   ms_cnt_w;
    logic [DLY_W-1:0]   target_w;

    pgq_sync #(
        .W (N_RAILS)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (rail_ok_async_i),
        .q_o    (rail_ok_s)
    );

    pgq_rail_combine #(
        .N_RAILS (N_RAILS)
    ) u_comb (
        .en_i   (rail_en_i),
        .ok_i   (rail_ok_s),
        .good_o (good_w)
    );

    pgq_prescale #(
        .TICK_DIV (TICK_DIV)
    ) u_pre (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (counting_w & good_w),
        .tick_o (tick_w)
    );

    pgq_qual_fsm #(
        .DLY_W   (DLY_W),
        .DLY_MIN (DLY_MIN),
        .DLY_MAX (DLY_MAX)
    ) u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .good_i     (good_w),
        .tick_i     (tick_w),
        .dly_ms_i   (dly_ms_i),
        .state_o    (st_w),
        .ms_cnt_o   (ms_cnt_w),
        .target_o   (target_w),
        .counting_o (counting_w),
        .rel_o      (rel_w)
    );

    // A fault pulls the pad low in the same cycle; release needs both.
    assign pg_release_o = rel_w & good_w;

endmodule

// File: rtl/pgq_chk.sv
// Module: pgq_chk
// Property checker for dual_rail_pgood, attached with bind below.
// Assumes: all inputs are the top's ports or internal nets, read only.
module pgq_chk
    import pgq_pkg::*;
#(
    parameter int unsigned N_RAILS = 2,
    parameter int unsigned DLY_W   = 8,
    parameter int unsigned DLY_MIN = 1,
    parameter int unsigned DLY_MAX = 200
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [N_RAILS-1:0] rail_en_i,
    input logic [N_RAILS-1:0] rail_ok_s,
    input logic               good_w,
    input logic               tick_w,
    input qstate_t            st_w,
    input logic [DLY_W-1:0]   ms_cnt_w,
    input logic [DLY_W-1:0]   target_w,
    input logic               pg_release_o
);

    localparam logic [DLY_W-1:0] MIN_V = DLY_W'(DLY_MIN);
    localparam logic [DLY_W-1:0] MAX_V = DLY_W'(DLY_MAX);

    // R1
    release_needs_enabled_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pg_release_o |-> ((rail_ok_s | ~rail_en_i) == '1));

    // R3
    none_enabled_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rail_en_i == '0) |-> !pg_release_o);

    // R4
    release_after_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_w == QS_REL) |-> ($past(tick_w) && $past(st_w) == QS_COUNT));

    // R4
    count_below_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_w == QS_COUNT) |-> (ms_cnt_w < target_w));

    // R5
    fault_to_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!good_w && st_w != QS_IDLE) |=> (st_w == QS_IDLE));

    // R6
    idle_count_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_w == QS_IDLE) |-> (ms_cnt_w == '0));

    // R7
    target_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (target_w >= MIN_V) && (target_w <= MAX_V));

    // R8
    target_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_w != QS_IDLE) |=> ((st_w == QS_IDLE) || $stable(target_w)));

    // R10
    reset_low_chk: assert property (@(posedge clk_i)
        !rst_ni |=> (st_w == QS_IDLE && !pg_release_o && ms_cnt_w == '0));

endmodule

bind dual_rail_pgood pgq_chk #(
    .N_RAILS (N_RAILS),
    .DLY_W   (DLY_W),
    .DLY_MIN (DLY_MIN),
    .DLY_MAX (DLY_MAX)
) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rail_en_i    (rail_en_i),
    .rail_ok_s    (rail_ok_s),
    .good_w       (good_w),
    .tick_w       (tick_w),
    .st_w         (st_w),
    .ms_cnt_w     (ms_cnt_w),
    .target_w     (target_w),
    .pg_release_o (pg_release_o)
);

// File: tb/dual_rail_pgood_tb_top.sv
// Bench for dual_rail_pgood: a behavioural reference model compared on
// every clock, plus edge-exact directed checks per requirement.
module dual_rail_pgood_tb_top;

    localparam int CLK_P = 10;
    localparam int DIV   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] en = 2'b00;
    logic [1:0] ok = 2'b00;
    logic [7:0] dly = 8'd3;
    logic       pg;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    string cur_req = "R10";
    bit    started = 1'b0;

    // reference model state
    logic [1:0] m_r1 = 2'b00;
    logic [1:0] m_r2 = 2'b00;
    bit         m_rel = 1'b0;
    int         m_run = 0;
    int         m_tgt = 1;

    dual_rail_pgood #(
        .N_RAILS  (2),
        .TICK_DIV (DIV),
        .DLY_W    (8),
        .DLY_MIN  (1),
        .DLY_MAX  (200)
    ) dut_i (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .rail_en_i       (en),
        .rail_ok_async_i (ok),
        .dly_ms_i        (dly),
        .pg_release_o    (pg)
    );

    always #(CLK_P / 2) clk = ~clk;

    function automatic bit gcf(logic [1:0] e, logic [1:0] k);
        return (e != 2'b00) && ((k | ~e) == 2'b11);
    endfunction

    function automatic int clampf(int d);
        if (d < 1) return 1;
        if (d > 200) return 200;
        return d;
    endfunction

    // Reference model: advance on each rising edge from pre-edge values.
    always @(posedge clk) begin
        bit g;
        started = 1'b1;
        cycles++;
        if (!rst_n) begin
            m_r1 = 2'b00; m_r2 = 2'b00; m_rel = 1'b0; m_run = 0;
        end else begin
            g = gcf(en, m_r2);
            if (!g) begin
                m_rel = 1'b0; m_run = 0;
            end else if (!m_rel) begin
                if (m_run == 0) m_tgt = clampf(int'(dly));
                m_run++;
                if (m_run == m_tgt * DIV + 1) m_rel = 1'b1;
            end
            m_r2 = m_r1;
            m_r1 = ok;
        end
    end

    // Per-cycle comparison against the model, mid-cycle.
    always @(negedge clk) begin
        bit exp;
        if (started) begin
            exp = m_rel && gcf(en, m_r2);
            checks++;
            if (pg !== exp) begin
                errors++;
                $display("FAIL %s model compare: actual %0b expected %0b at cycle %0d",
                         cur_req, pg, exp, cycles);
            end
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic drive(input logic [1:0] e, input logic [1:0] k, input logic [7:0] d);
        @(negedge clk); #1;
        en = e; ok = k; dly = d;
    endtask

    task automatic set_rst(input logic r);
        @(negedge clk); #1;
        rst_n = r;
    endtask

    // Wait n rising edges, then compare the output a quarter period later.
    task automatic wait_check(input int n, input logic exp, input string tag);
        repeat (n) @(posedge clk);
        #(CLK_P / 4);
        checks++;
        if (pg !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", tag, pg, exp);
        end
    endtask

    initial begin
        // R10: reset state
        cur_req = "R10";
        wait_check(3, 1'b0, "R10 reset holds output low");
        set_rst(1'b1);
        drive(2'b11, 2'b00, 8'd3);
        wait_check(4, 1'b0, "R1 both enabled, both flags low");

        // R4 / R1: both rails come good, 3 ms delay
        cur_req = "R4";
        drive(2'b11, 2'b11, 8'd3);
        wait_check(14, 1'b0, "R4 still counting one edge before release");
        wait_check(1, 1'b1, "R4 release at 3*DIV edges after seen");

        // R9 / R5: rail 0 drops, two-stage latency then immediate low
        cur_req = "R5";
        drive(2'b11, 2'b10, 8'd3);
        wait_check(1, 1'b1, "R9 flag change not yet through synchronizer");
        wait_check(1, 1'b0, "R5 fault pulls output low at once (R1 rail 0 bad)");

        // R2: only rail 0 enabled, rail 1 flag ignored
        cur_req = "R2";
        drive(2'b01, 2'b01, 8'd3);
        wait_check(14, 1'b0, "R2 single rail still counting");
        wait_check(1, 1'b1, "R2 single rail released");
        drive(2'b01, 2'b11, 8'd3);
        wait_check(4, 1'b1, "R2 disabled rail flag high has no effect");
        drive(2'b01, 2'b01, 8'd3);
        wait_check(4, 1'b1, "R2 disabled rail flag low has no effect");
        drive(2'b01, 2'b10, 8'd3);
        wait_check(2, 1'b0, "R2 enabled rail flag low pulls output low");

        // R3: no rail enabled
        cur_req = "R3";
        drive(2'b00, 2'b11, 8'd3);
        wait_check(1, 1'b0, "R3 none enabled");
        wait_check(40, 1'b0, "R3 none enabled with both flags high");

        // R7: clamp of 0 and of 255
        cur_req = "R7";
        drive(2'b11, 2'b11, 8'd0);
        wait_check(4, 1'b0, "R7 zero delay before 1 ms");
        wait_check(1, 1'b1, "R7 zero delay acts as 1 ms");
        drive(2'b00, 2'b11, 8'd255);
        wait_check(1, 1'b0, "R3 disable drops output");
        drive(2'b11, 2'b11, 8'd255);
        wait_check(800, 1'b0, "R7 large delay before 200 ms");
        wait_check(1, 1'b1, "R7 delay above 200 acts as 200 ms");

        // R8: delay write while released only applies next time
        cur_req = "R8";
        drive(2'b11, 2'b11, 8'd2);
        wait_check(20, 1'b1, "R8 write while released has no effect");
        drive(2'b00, 2'b11, 8'd2);
        wait_check(1, 1'b0, "R8 disable drops output");
        drive(2'b11, 2'b11, 8'd2);
        wait_check(8, 1'b0, "R8 new delay counting");
        wait_check(1, 1'b1, "R8 new delay used on next qualification");

        // R6: glitch mid-count restarts from zero
        cur_req = "R6";
        drive(2'b00, 2'b11, 8'd5);
        wait_check(1, 1'b0, "R6 disable before run");
        drive(2'b11, 2'b11, 8'd5);
        wait_check(10, 1'b0, "R6 halfway through count");
        drive(2'b00, 2'b11, 8'd5);
        wait_check(1, 1'b0, "R6 glitch low");
        drive(2'b11, 2'b11, 8'd5);
        wait_check(20, 1'b0, "R6 count restarted, not resumed");
        wait_check(1, 1'b1, "R6 full delay after restart");

        // R10: reset while released
        cur_req = "R10";
        set_rst(1'b0);
        wait_check(1, 1'b0, "R10 reset forces output low");
        set_rst(1'b1);
        wait_check(22, 1'b0, "R10 counter and synchronizer cleared");
        wait_check(1, 1'b1, "R10 release after full delay from reset");

        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule